// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

Two single-word registers carry messages between two independently clocked sides without going through a FIFO. Side A deposits a word in mailbox 1, and side B collects it. Side B deposits a word in mailbox 2, and side A collects it. On each side a select input decides whether a read or write targets the mailbox or the FIFO path. When the FIFO path is selected, the block only raises the matching FIFO strobe and passes the FIFO output word through to the read data port.

Every mailbox has an active-low full flag in the domain of its writer. The flag falls on the clock edge that stores a word. While it is low, further writes are refused. It rises again once the reader has consumed the word.

Write and consume events are exchanged as toggles through two-flop synchronizers. The stored word stays frozen while the flag is low, so the data bus itself needs no synchronizer. Each mailbox has its own asynchronous active-low reset, which is driven by the reset of the FIFO it sits beside. The data width is a parameter and is set to the narrow-port width.

Top module: `mbox_pair`

## Requirements
- R1: On a rising `clk_a` edge with `a_en`=1, `a_wr`=1, `a_mbsel`=1 and `mb1_full_n`=1, `a_din` is stored in mailbox 1 and `mb1_full_n` is 0 after that edge (the symmetric case on side B is R7).
- R2: With the select low, an enabled write raises the side's FIFO write strobe and an enabled read raises its FIFO read strobe. With the select high or the enable low, both strobes are 0, and a FIFO-path write leaves the mailbox unchanged.
- R3: A mailbox write attempted while the flag is 0 is ignored: the reader later collects the first word.
- R4: A read on the other side (`b_en`=1, `b_wr`=0, `b_mbsel`=1) while mail is pending returns the stored word on `b_dout`. Within a few writer-clock cycles after that read, the flag returns to 1.
- R5: The read data port shows the opposite mailbox when its select is 1 and the FIFO output word when its select is 0, in the same cycle.
- R6: Reset (`mb1_rst_n` or `mb2_rst_n` low) forces the matching flag to 1 and the matching mailbox contents to 0, even when mail is pending.
- R7: Mailbox 2 behaves symmetrically: side B writes it, `mb2_full_n` (in the `clk_b` domain) falls after the write, side A reads it, and the flag rises again.
- R8: The flag stays 0 for as long as the word remains unread, however many cycles pass.
- R9: A mailbox read when no mail is pending has no effect: a later write still leaves the flag low until a real read occurs.
- R10: With the enable low, a write with the select high neither stores data nor lowers the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| clk_b | input | 1 | Side B clock |
| mb1_rst_n | input | 1 | Asynchronous active-low reset of mailbox 1 |
| mb2_rst_n | input | 1 | Asynchronous active-low reset of mailbox 2 |
| a_en | input | 1 | Side A access enable |
| a_wr | input | 1 | Side A direction: 1 write, 0 read |
| a_mbsel | input | 1 | Side A target: 1 mailbox, 0 FIFO |
| a_din | input | W | Side A write data |
| a_fifo_q | input | W | Output word of the FIFO read by side A |
| a_dout | output | W | Side A read data |
| a_fifo_wr | output | 1 | Write strobe to the FIFO from side A |
| a_fifo_rd | output | 1 | Read strobe to the FIFO read by side A |
| mb1_full_n | output | 1 | Mailbox 1 flag, 0 while holding unread mail (clk_a domain) |
| b_en | input | 1 | Side B access enable |
| b_wr | input | 1 | Side B direction: 1 write, 0 read |
| b_mbsel | input | 1 | Side B target: 1 mailbox, 0 FIFO |
| b_din | input | W | Side B write data |
| b_fifo_q | input | W | Output word of the FIFO read by side B |
| b_dout | output | W | Side B read data |
| b_fifo_wr | output | 1 | Write strobe to the FIFO from side B |
| b_fifo_rd | output | 1 | Read strobe to the FIFO read by side B |
| mb2_full_n | output | 1 | Mailbox 2 flag, 0 while holding unread mail (clk_b domain) |

## Verification
The hardest case to reach from the ports is a consume event that has no mail behind it. Such an event would throw the toggle pair out of step, and the only sign would be a flag that later reads the wrong level. To provoke it, the stimulus first completes a full write, read and acknowledge round trip. It then issues a mailbox read on the empty box, writes fresh mail, and checks that the flag stays low for many cycles until a genuine read arrives. The two clocks run at unrelated periods, so the synchronizer delays land in varying phases from one round trip to the next.

// File: rtl/mbox_pair.sv
module mbox_pair #(
  parameter int W    = 18,
  parameter int SYNC = 2
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         mb1_rst_n,
  input  logic         mb2_rst_n,
  input  logic         a_en,
  input  logic         a_wr,
  input  logic         a_mbsel,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_dout,
  output logic         a_fifo_wr,
  output logic         a_fifo_rd,
  output logic         mb1_full_n,
  input  logic         b_en,
  input  logic         b_wr,
  input  logic         b_mbsel,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_dout,
  output logic         b_fifo_wr,
  output logic         b_fifo_rd,
  output logic         mb2_full_n
);
  localparam int TOP = SYNC - 1;

  logic [W-1:0]    mb1_q, mb2_q;
  logic            a_wtog, b_ack1, b_wtog, a_ack2;
  logic [SYNC-1:0] a_ack1_s, b_wtog1_s, b_ack2_s, a_wtog2_s;
  logic            a_put, b_take, b_put, a_take;

  assign mb1_full_n = (a_wtog == a_ack1_s[TOP]);
  assign mb2_full_n = (b_wtog == b_ack2_s[TOP]);

  assign a_put  = a_en & a_wr  & a_mbsel & mb1_full_n;
  assign b_take = b_en & ~b_wr & b_mbsel & (b_wtog1_s[TOP] != b_ack1);
  assign b_put  = b_en & b_wr  & b_mbsel & mb2_full_n;
  assign a_take = a_en & ~a_wr & a_mbsel & (a_wtog2_s[TOP] != a_ack2);

  assign a_fifo_wr = a_en & a_wr  & ~a_mbsel;
  assign a_fifo_rd = a_en & ~a_wr & ~a_mbsel;
  assign b_fifo_wr = b_en & b_wr  & ~b_mbsel;
  assign b_fifo_rd = b_en & ~b_wr & ~b_mbsel;

  assign a_dout = a_mbsel ? mb2_q : a_fifo_q;
  assign b_dout = b_mbsel ? mb1_q : b_fifo_q;

  always_ff @(posedge clk_a or negedge mb1_rst_n)
    if (!mb1_rst_n) begin
      a_wtog   <= 1'b0;
      mb1_q    <= '0;
      a_ack1_s <= '0;
    end else begin
      a_ack1_s <= {a_ack1_s[SYNC-2:0], b_ack1};
      if (a_put) begin
        mb1_q  <= a_din;
        a_wtog <= ~a_wtog;
      end
    end

  always_ff @(posedge clk_b or negedge mb1_rst_n)
    if (!mb1_rst_n) begin
      b_ack1    <= 1'b0;
      b_wtog1_s <= '0;
    end else begin
      b_wtog1_s <= {b_wtog1_s[SYNC-2:0], a_wtog};
      if (b_take) b_ack1 <= ~b_ack1;
    end

  always_ff @(posedge clk_b or negedge mb2_rst_n)
    if (!mb2_rst_n) begin
      b_wtog   <= 1'b0;
      mb2_q    <= '0;
      b_ack2_s <= '0;
    end else begin
      b_ack2_s <= {b_ack2_s[SYNC-2:0], a_ack2};
      if (b_put) begin
        mb2_q  <= b_din;
        b_wtog <= ~b_wtog;
      end
    end

  always_ff @(posedge clk_a or negedge mb2_rst_n)
    if (!mb2_rst_n) begin
      a_ack2    <= 1'b0;
      a_wtog2_s <= '0;
    end else begin
      a_wtog2_s <= {a_wtog2_s[SYNC-2:0], b_wtog};
      if (a_take) a_ack2 <= ~a_ack2;
    end
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int W = 18
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         mb1_rst_n,
  input logic         mb2_rst_n,
  input logic         a_en,
  input logic         a_wr,
  input logic         a_mbsel,
  input logic         a_fifo_wr,
  input logic         mb1_full_n,
  input logic         b_en,
  input logic         b_wr,
  input logic         b_mbsel,
  input logic         b_fifo_wr,
  input logic         mb2_full_n,
  input logic [W-1:0] mb1_q,
  input logic [W-1:0] mb2_q
);
  p_flag1_low_after_put_r1: assert property (@(posedge clk_a) disable iff (!mb1_rst_n)
    (a_en && a_wr && a_mbsel && mb1_full_n) |=> !mb1_full_n);

  p_flag1_falls_only_on_put_r1: assert property (@(posedge clk_a) disable iff (!mb1_rst_n)
    $fell(mb1_full_n) |-> $past(a_en && a_wr && a_mbsel));

  p_mb1_frozen_r3: assert property (@(posedge clk_a) disable iff (!mb1_rst_n)
    !mb1_full_n |=> $stable(mb1_q));

  p_fifo_write_spares_mb1_r2: assert property (@(posedge clk_a) disable iff (!mb1_rst_n)
    a_fifo_wr |=> $stable(mb1_q));

  p_flag2_low_after_put_r7: assert property (@(posedge clk_b) disable iff (!mb2_rst_n)
    (b_en && b_wr && b_mbsel && mb2_full_n) |=> !mb2_full_n);

  p_mb2_frozen_r3: assert property (@(posedge clk_b) disable iff (!mb2_rst_n)
    !mb2_full_n |=> $stable(mb2_q));

  p_fifo_write_spares_mb2_r2: assert property (@(posedge clk_b) disable iff (!mb2_rst_n)
    b_fifo_wr |=> $stable(mb2_q));
endmodule

bind mbox_pair mbox_pair_chk #(.W(W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .mb1_rst_n(mb1_rst_n), .mb2_rst_n(mb2_rst_n),
  .a_en(a_en), .a_wr(a_wr), .a_mbsel(a_mbsel), .a_fifo_wr(a_fifo_wr),
  .mb1_full_n(mb1_full_n), .b_en(b_en), .b_wr(b_wr), .b_mbsel(b_mbsel),
  .b_fifo_wr(b_fifo_wr), .mb2_full_n(mb2_full_n), .mb1_q(mb1_q), .mb2_q(mb2_q)
);

// File: tb/mbox_pair_test.sv
`timescale 1ns/1ps
module mbox_pair_test;
  localparam int W = 18;

  logic clk_a = 0, clk_b = 0;
  logic mb1_rst_n = 0, mb2_rst_n = 0;
  logic a_en = 0, a_wr = 0, a_mbsel = 0;
  logic b_en = 0, b_wr = 0, b_mbsel = 0;
  logic [W-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_fifo_wr, a_fifo_rd, b_fifo_wr, b_fifo_rd, mb1_full_n, mb2_full_n;

  int checks = 0, fails = 0;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  mbox_pair #(.W(W)) uut (.*);

  // {en, wr, sel, din, fifo_q, exp_dout, exp_fifo_wr, exp_fifo_rd}
  localparam logic [58:0] VEC [8] = '{
    {3'b110, 18'h00011, 18'h3FFFF, 18'h3FFFF, 2'b10},
    {3'b100, 18'h00000, 18'h15555, 18'h15555, 2'b01},
    {3'b111, 18'h2AAAA, 18'h00F0F, 18'h00000, 2'b00},
    {3'b101, 18'h00000, 18'h12345, 18'h00000, 2'b00},
    {3'b010, 18'h00007, 18'h0ABCD, 18'h0ABCD, 2'b00},
    {3'b000, 18'h00000, 18'h00001, 18'h00001, 2'b00},
    {3'b001, 18'h00000, 18'h3C3C3, 18'h00000, 2'b00},
    {3'b110, 18'h3F00F, 18'h00000, 18'h00000, 2'b10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic a_put(input logic [W-1:0] d);
    @(posedge clk_a); #1;
    a_en = 1; a_wr = 1; a_mbsel = 1; a_din = d;
    @(posedge clk_a); #1;
    a_en = 0; a_wr = 0; a_mbsel = 0;
  endtask

  task automatic b_put(input logic [W-1:0] d);
    @(posedge clk_b); #1;
    b_en = 1; b_wr = 1; b_mbsel = 1; b_din = d;
    @(posedge clk_b); #1;
    b_en = 0; b_wr = 0; b_mbsel = 0;
  endtask

  task automatic b_take(input string tag, input logic [W-1:0] exp);
    @(posedge clk_b); #1;
    b_en = 1; b_wr = 0; b_mbsel = 1;
    #1 chk(tag, b_dout, exp);
    @(posedge clk_b); #1;
    b_en = 0; b_mbsel = 0;
  endtask

  task automatic a_take(input string tag, input logic [W-1:0] exp);
    @(posedge clk_a); #1;
    a_en = 1; a_wr = 0; a_mbsel = 1;
    #1 chk(tag, a_dout, exp);
    @(posedge clk_a); #1;
    a_en = 0; a_mbsel = 0;
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(posedge clk_a);
    #1;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // Vector table, applied while both mailboxes are held in reset (R2, R5)
    for (int i = 0; i < 8; i++) begin
      {a_en, a_wr, a_mbsel, a_din, a_fifo_q} = VEC[i][58:20];
      {b_en, b_wr, b_mbsel, b_din, b_fifo_q} = VEC[i][58:20];
      #2;
      chk("R5 a_dout", a_dout, VEC[i][19:2]);
      chk("R2 a_fifo_wr", a_fifo_wr, VEC[i][1]);
      chk("R2 a_fifo_rd", a_fifo_rd, VEC[i][0]);
      chk("R5 b_dout", b_dout, VEC[i][19:2]);
      chk("R2 b_fifo_wr", b_fifo_wr, VEC[i][1]);
      chk("R2 b_fifo_rd", b_fifo_rd, VEC[i][0]);
    end
    {a_en, a_wr, a_mbsel, b_en, b_wr, b_mbsel} = '0;
    a_fifo_q = 18'h0F0F0; b_fifo_q = 18'h30303;
    chk("R6 flag1 in reset", mb1_full_n, 1);
    chk("R6 flag2 in reset", mb2_full_n, 1);

    @(posedge clk_a); #1;
    mb1_rst_n = 1; mb2_rst_n = 1;
    wait_a(4);
    chk("R6 flag1 after reset", mb1_full_n, 1);
    chk("R6 flag2 after reset", mb2_full_n, 1);

    // FIFO-path write leaves mailbox alone (R2)
    @(posedge clk_a); #1;
    a_en = 1; a_wr = 1; a_mbsel = 0; a_din = 18'h2FFFF;
    wait_a(1);
    a_en = 0; a_wr = 0;
    chk("R2 flag1 after FIFO write", mb1_full_n, 1);
    wait_a(2);
    b_mbsel = 1; #1;
    chk("R2 mailbox1 untouched", b_dout, 18'h00000);
    b_mbsel = 0;

    // Mailbox 1 round trip (R1, R3, R8, R4)
    a_put(18'h01234);
    chk("R1 flag1 low after write", mb1_full_n, 0);
    wait_a(20);
    chk("R8 flag1 stays low unread", mb1_full_n, 0);
    a_put(18'h00BAD);
    chk("R3 flag1 still low", mb1_full_n, 0);
    wait_a(4);
    b_take("R3 first word kept", 18'h01234);
    wait_a(8);
    chk("R4 flag1 high after read", mb1_full_n, 1);

    // Mailbox 2 round trip (R7)
    b_put(18'h002A5);
    chk("R7 flag2 low after write", mb2_full_n, 0);
    wait_a(10);
    a_take("R7 side A reads mailbox2", 18'h002A5);
    repeat (8) @(posedge clk_b); #1;
    chk("R7 flag2 high after read", mb2_full_n, 1);

    // Read of an empty mailbox has no effect (R9)
    b_take("R9 empty read data", 18'h01234);
    wait_a(8);
    chk("R9 flag1 high after empty read", mb1_full_n, 1);
    a_put(18'h03333);
    wait_a(20);
    chk("R9 flag1 low until real read", mb1_full_n, 0);
    b_take("R9 real read", 18'h03333);
    wait_a(8);
    chk("R9 flag1 high after real read", mb1_full_n, 1);

    // Enable low blocks mailbox write (R10)
    @(posedge clk_a); #1;
    a_en = 0; a_wr = 1; a_mbsel = 1; a_din = 18'h11111;
    wait_a(5);
    a_wr = 0; a_mbsel = 0;
    chk("R10 flag1 unchanged", mb1_full_n, 1);
    wait_a(4);
    b_mbsel = 1; #1;
    chk("R10 mailbox1 unchanged", b_dout, 18'h03333);
    b_mbsel = 0;

    // Reset with mail pending (R6)
    a_put(18'h15A5A);
    chk("R6 flag1 low before reset", mb1_full_n, 0);
    #1 mb1_rst_n = 0;
    #1;
    chk("R6 flag1 high in reset", mb1_full_n, 1);
    b_mbsel = 1; #1;
    chk("R6 mailbox1 cleared", b_dout, 18'h00000);
    b_mbsel = 0;
    @(posedge clk_a); #1 mb1_rst_n = 1;
    wait_a(6);
    chk("R6 flag1 high after reset", mb1_full_n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule